// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 12-bit-plus-sign successive-approximation converter. It watches five active-low control pins (select, write, sample/hold, calibrate, zero-enable) and walks the analog core through its phases. Those phases are a two-part calibration, an optional fixed-length comparator zeroing phase, an acquisition window and a bit-serial approximation. One comparator bit from the analog side decides each trial bit of the DAC code.

Three paths start work. A write rising edge either converts at once or first zeroes and then acquires for a fixed time. A sample/hold low pulse opens and closes the acquisition window by hand. A low level on the calibrate pin aborts anything in progress and runs calibration. The analog measurement and correction logic sit outside the block. They are driven through one-hot phase strobes and the DAC code output. The result comes out in two's complement with a one-clock done pulse.

Top module: `sar_conv_seq`

## Requirements
- R1: While and after reset, `ready_o` is 1. `done_o`, all phase strobes, `dac_code_o` and `result_o` are 0.
- R2: Any clock edge that samples `cal_n` low places the block in the offset-calibration phase (`cal_ofs_o`=1, `ready_o`=0), whatever it was doing before.
- R3: After the last edge that samples `cal_n` low, `cal_ofs_o` stays high for CAL_OFS_LEN cycles (default 128). `cal_mis_o` is then high for the remaining cycles. `ready_o` returns high exactly CAL_TOTAL edges (default 1399) after that last low edge.
- R4: In ready state, with `cs_n` low and `az_n` high, a `wr_n` rising edge starts the approximation at that edge. `conv_o` is high for 13 cycles, `done_o` rises 13 edges later, and `zero_o` and `acq_o` stay low.
- R5: When `az_n` is low at the write edge, `zero_o` is high for ZERO_LEN cycles (default 26) and then `acq_o` for ACQ_LEN cycles (default 7). The approximation follows. `done_o` comes ZERO_LEN+ACQ_LEN edges later than in R4.
- R6: A `wr_n` rising edge while `cs_n` is high starts nothing: `ready_o` stays 1 and no `done_o` follows.
- R7: In ready state with `cs_n` low, a `sh_n` falling edge raises `acq_o`. The next `sh_n` rising edge with `cs_n` low starts the approximation, and `done_o` rises 13 edges later.
- R8: The approximation tries bit 12 first, then 11 down to 0, one clock per bit. The trial bit is set in `dac_code_o`. On the next edge it is kept if `comp_in` is 1 (DAC code at or below the input) and cleared if 0. At each step, bits below the trial bit are 0.
- R9: `done_o` is a single-cycle pulse, given only in ready state. `result_o` = {~code[12], code[11:0]} of the final code, so code 0 gives -4096 and code 8191 gives +4095. It holds between done pulses.
- R10: Write and sample/hold edges that arrive while `ready_o` is 0 are ignored, and the running sequence keeps its timing.
- R11: At most one of `ready_o`, `cal_ofs_o`, `cal_mis_o`, `zero_o`, `acq_o`, `conv_o` is high in any cycle. `ready_o` is 0 in every non-idle phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write; rising edge starts a conversion |
| sh_n | input | 1 | Sample/hold; falling edge opens, rising edge closes acquisition |
| cal_n | input | 1 | Calibrate, active-low level |
| az_n | input | 1 | Zeroing enable, active low, sampled at the write edge |
| comp_in | input | 1 | Comparator: 1 when the DAC code is at or below the input |
| ready_o | output | 1 | High when idle (end of conversion), low while busy |
| cal_ofs_o | output | 1 | Offset calibration phase strobe |
| cal_mis_o | output | 1 | DAC mismatch calibration phase strobe |
| zero_o | output | 1 | Comparator zeroing phase strobe |
| acq_o | output | 1 | Acquisition window strobe |
| conv_o | output | 1 | Approximation phase strobe |
| dac_code_o | output | 13 | Trial code to the DAC |
| result_o | output | 13 | Two's complement result |
| done_o | output | 1 | One-cycle conversion complete pulse |

## Verification
Embedded properties check on every cycle that:
- the phase strobes never overlap;
- a low calibrate sample always lands in the offset phase;
- the mismatch phase only follows the offset phase;
- zeroing is followed by acquisition, and is not cut short by other start edges;
- every approximation step has its trial bit set and all lower bits clear;
- done is a one-cycle pulse in ready state, and the result holds between pulses.

Some things only the directed scenarios can show:
- the exact cycle counts of calibration, zeroing, acquisition and the approximation;
- the trial-code sequence for a known input;
- the two's complement values at the extremes;
- that a deselected write, or edges during a busy sequence, leave the timing unchanged.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int RES_W        = 13;
    localparam int CAL_TOTAL_D  = 1399;
    localparam int CAL_OFS_D    = 128;
    localparam int ZERO_LEN_D   = 26;
    localparam int ACQ_LEN_D    = 7;

    // index of each edge-detected pin in the edge detector vector
    localparam int PIN_WR = 0;
    localparam int PIN_SH = 1;
    localparam int PIN_N  = 2;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_CAL_OFS = 3'd1,
        PH_CAL_MIS = 3'd2,
        PH_ZERO    = 3'd3,
        PH_ACQ     = 3'd4,
        PH_SH_ACQ  = 3'd5,
        PH_CONV    = 3'd6
    } phase_e;

    typedef struct packed {
        logic wr_go;     // qualified write rising edge
        logic sh_open;   // qualified sample/hold falling edge
        logic sh_close;  // qualified sample/hold rising edge
    } start_req_t;

    typedef struct packed {
        logic ready;
        logic cal_ofs;
        logic cal_mis;
        logic zero;
        logic acq;
        logic conv;
    } strobes_t;

    function automatic strobes_t decode_phase(phase_e ph);
        strobes_t s;
        s         = '0;
        s.ready   = (ph == PH_IDLE);
        s.cal_ofs = (ph == PH_CAL_OFS);
        s.cal_mis = (ph == PH_CAL_MIS);
        s.zero    = (ph == PH_ZERO);
        s.acq     = (ph == PH_ACQ) || (ph == PH_SH_ACQ);
        s.conv    = (ph == PH_CONV);
        return s;
    endfunction

endpackage

// File: rtl/sar_pin_edges.sv
module sar_pin_edges #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] chg_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= pin_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_chg
        assign chg_o[g] = prev_q[g] ^ pin_i[g];
    end
endmodule

// File: rtl/sar_phase_timer.sv
module sar_phase_timer #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_o <= '0;
        else              cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         step_i,
    input  logic         comp_i,
    output logic         last_o,
    output logic [W-1:0] code_o,
    output logic [W-1:0] result_o,
    output logic         done_o
);
    localparam int IW = $clog2(W);
    localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

    logic [IW-1:0] idx_q;
    logic [W-1:0]  nxt_code;
    logic [W-1:0]  low_mask;

    always_comb begin
        nxt_code = code_o;
        if (!comp_i) nxt_code[idx_q] = 1'b0;
        if (idx_q != '0) nxt_code[idx_q - 1'b1] = 1'b1;
    end

    always_comb low_mask = ({{(W-1){1'b0}}, 1'b1} << idx_q) - 1'b1;

    assign last_o = step_i && (idx_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o   <= '0;
            idx_q    <= '0;
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                code_o <= {1'b1, {(W-1){1'b0}}};
                idx_q  <= TOP_IDX;
            end else if (step_i) begin
                code_o <= nxt_code;
                if (idx_q == '0) begin
                    result_o <= {~nxt_code[W-1], nxt_code[W-2:0]};
                    done_o   <= 1'b1;
                end else begin
                    idx_q <= idx_q - 1'b1;
                end
            end
        end
    end

    // R8: trial bit is set when it is evaluated
    p_trial_set_r8: assert property (@(posedge clk) disable iff (rst)
        step_i |-> code_o[idx_q]);
    // R8: bits below the trial bit are still clear
    p_low_clear_r8: assert property (@(posedge clk) disable iff (rst)
        step_i |-> ((code_o & low_mask) == '0));
    // R9: done lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R9: result only moves together with done
    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int RES_W       = sar_seq_pkg::RES_W,
    parameter int CAL_TOTAL   = sar_seq_pkg::CAL_TOTAL_D,
    parameter int CAL_OFS_LEN = sar_seq_pkg::CAL_OFS_D,
    parameter int ZERO_LEN    = sar_seq_pkg::ZERO_LEN_D,
    parameter int ACQ_LEN     = sar_seq_pkg::ACQ_LEN_D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             sh_n,
    input  logic             cal_n,
    input  logic             az_n,
    input  logic             comp_in,
    output logic             ready_o,
    output logic             cal_ofs_o,
    output logic             cal_mis_o,
    output logic             zero_o,
    output logic             acq_o,
    output logic             conv_o,
    output logic [RES_W-1:0] dac_code_o,
    output logic [RES_W-1:0] result_o,
    output logic             done_o
);
    import sar_seq_pkg::*;

    localparam int CAL_MIS_LEN = CAL_TOTAL - CAL_OFS_LEN;
    localparam int CW          = $clog2(CAL_TOTAL + 1);
    localparam logic [CW-1:0] OFS_END  = CW'(CAL_OFS_LEN - 1);
    localparam logic [CW-1:0] MIS_END  = CW'(CAL_MIS_LEN - 1);
    localparam logic [CW-1:0] ZERO_END = CW'(ZERO_LEN - 1);
    localparam logic [CW-1:0] ACQ_END  = CW'(ACQ_LEN - 1);

    phase_e      ph_q, ph_n;
    logic [CW-1:0] cnt;
    logic        tmr_clr;
    logic        sar_start, sar_step, sar_last;
    logic [PIN_N-1:0] pins, chg;
    start_req_t  req;
    strobes_t    stb;

    assign pins[PIN_WR] = wr_n;
    assign pins[PIN_SH] = sh_n;

    sar_pin_edges #(.N(PIN_N)) u_edges (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pins),
        .chg_o (chg)
    );

    always_comb begin
        req.wr_go    = chg[PIN_WR] &&  wr_n && !cs_n;
        req.sh_open  = chg[PIN_SH] && !sh_n && !cs_n;
        req.sh_close = chg[PIN_SH] &&  sh_n && !cs_n;
    end

    sar_phase_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr_i (tmr_clr),
        .cnt_o (cnt)
    );

    always_comb begin
        ph_n      = ph_q;
        tmr_clr   = 1'b0;
        sar_start = 1'b0;
        if (!cal_n) begin
            ph_n    = PH_CAL_OFS;
            tmr_clr = 1'b1;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    tmr_clr = 1'b1;
                    if (req.wr_go) begin
                        if (az_n) begin
                            ph_n      = PH_CONV;
                            sar_start = 1'b1;
                        end else begin
                            ph_n = PH_ZERO;
                        end
                    end else if (req.sh_open) begin
                        ph_n = PH_SH_ACQ;
                    end
                end
                PH_CAL_OFS: if (cnt == OFS_END) begin
                    ph_n    = PH_CAL_MIS;
                    tmr_clr = 1'b1;
                end
                PH_CAL_MIS: if (cnt == MIS_END) begin
                    ph_n    = PH_IDLE;
                    tmr_clr = 1'b1;
                end
                PH_ZERO: if (cnt == ZERO_END) begin
                    ph_n    = PH_ACQ;
                    tmr_clr = 1'b1;
                end
                PH_ACQ: if (cnt == ACQ_END) begin
                    ph_n      = PH_CONV;
                    tmr_clr   = 1'b1;
                    sar_start = 1'b1;
                end
                PH_SH_ACQ: begin
                    tmr_clr = 1'b1;
                    if (req.sh_close) begin
                        ph_n      = PH_CONV;
                        sar_start = 1'b1;
                    end
                end
                PH_CONV: begin
                    tmr_clr = 1'b1;
                    if (sar_last) ph_n = PH_IDLE;
                end
                default: begin
                    ph_n    = PH_IDLE;
                    tmr_clr = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_n;
    end

    assign sar_step = (ph_q == PH_CONV) && cal_n;

    sar_approx_reg #(.W(RES_W)) u_sar (
        .clk      (clk),
        .rst      (rst),
        .start_i  (sar_start),
        .step_i   (sar_step),
        .comp_i   (comp_in),
        .last_o   (sar_last),
        .code_o   (dac_code_o),
        .result_o (result_o),
        .done_o   (done_o)
    );

    always_comb stb = decode_phase(ph_q);

    assign ready_o   = stb.ready;
    assign cal_ofs_o = stb.cal_ofs;
    assign cal_mis_o = stb.cal_mis;
    assign zero_o    = stb.zero;
    assign acq_o     = stb.acq;
    assign conv_o    = stb.conv;

    // R2: a low calibrate sample always lands in the offset phase
    p_cal_abort_r2: assert property (@(posedge clk) disable iff (rst)
        !cal_n |=> (cal_ofs_o && !ready_o));
    // R3: mismatch phase only follows the offset phase
    p_ofs_first_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_mis_o) |-> $past(cal_ofs_o));
    // R4: direct write start enters approximation at once
    p_direct_start_r4: assert property (@(posedge clk) disable iff (rst)
        (ready_o && req.wr_go && az_n && cal_n) |=> conv_o);
    // R5: zeroing is followed by acquisition unless calibration aborts
    p_zero_then_acq_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(zero_o) |-> (acq_o || cal_ofs_o));
    // R10: start edges during zeroing do not restart it
    p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (zero_o && cal_n) |=> (zero_o || acq_o));
    // R9: done only in ready state
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ready_o);
    // R11: phase strobes never overlap
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ready_o, cal_ofs_o, cal_mis_o, zero_o, acq_o, conv_o}));
endmodule

// File: tb/tb_sar_conv_seq.sv
`timescale 1ns/1ps
module tb_sar_conv_seq;
    logic clk = 1'b0;
    logic rst;
    logic cs_n, wr_n, sh_n, cal_n, az_n;
    logic comp_in;
    logic ready_o, cal_ofs_o, cal_mis_o, zero_o, acq_o, conv_o, done_o;
    logic [12:0] dac_code_o, result_o;
    logic [12:0] target;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign comp_in = (dac_code_o <= target);

    sar_conv_seq dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .sh_n(sh_n),
        .cal_n(cal_n), .az_n(az_n), .comp_in(comp_in),
        .ready_o(ready_o), .cal_ofs_o(cal_ofs_o), .cal_mis_o(cal_mis_o),
        .zero_o(zero_o), .acq_o(acq_o), .conv_o(conv_o),
        .dac_code_o(dac_code_o), .result_o(result_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic int twos(input logic [12:0] code);
        return int'({~code[12], code[11:0]});
    endfunction

    // counts negedges after the last drive until done, tallying strobes
    task automatic watch(input int limit, output int done_at, output int nz,
                         output int na, output int nc);
        done_at = -1; nz = 0; na = 0; nc = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (zero_o) nz++;
            if (acq_o)  na++;
            if (conv_o) nc++;
            if (done_o) begin
                done_at = i;
                break;
            end
        end
    endtask

    task automatic pulse_wr();
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
    endtask

    task automatic t_reset();
        check(ready_o == 1'b1, "R1 ready", int'(ready_o), 1);
        check(done_o == 1'b0, "R1 done", int'(done_o), 0);
        check({cal_ofs_o, cal_mis_o, zero_o, acq_o, conv_o} == 5'b0, "R1 strobes",
              int'({cal_ofs_o, cal_mis_o, zero_o, acq_o, conv_o}), 0);
        check(dac_code_o == 13'd0, "R1 dac", int'(dac_code_o), 0);
        check(result_o == 13'd0, "R1 result", int'(result_o), 0);
    endtask

    task automatic t_calibrate();
        int mis_at = -1, rdy_at = -1;
        @(negedge clk); cal_n = 1'b0;
        @(negedge clk);
        check(cal_ofs_o && !ready_o, "R2 cal entry", int'({cal_ofs_o, ready_o}), 2);
        cal_n = 1'b1;
        for (int i = 1; i <= 1500; i++) begin
            @(negedge clk);
            if (cal_mis_o && mis_at < 0) mis_at = i;
            if (ready_o) begin rdy_at = i; break; end
        end
        check(mis_at == 128, "R3 mismatch start", mis_at, 128);
        check(rdy_at == 1399, "R3 cal length", rdy_at, 1399);
    endtask

    task automatic t_direct(input logic [12:0] tgt);
        int d, nz, na, nc;
        target = tgt; az_n = 1'b1; cs_n = 1'b0;
        pulse_wr();
        watch(100, d, nz, na, nc);
        check(d == 14, "R4 done timing", d, 14);
        check(nc == 13, "R4 conv cycles", nc, 13);
        check(nz == 0 && na == 0, "R4 no zero/acq", nz + na, 0);
        check(int'(result_o) == twos(tgt), "R9 result", int'(result_o), twos(tgt));
        @(negedge clk);
        check(!done_o && ready_o, "R9 done pulse", int'({done_o, ready_o}), 1);
    endtask

    task automatic t_zeroing();
        int d, nz, na, nc;
        target = 13'h0123; az_n = 1'b0; cs_n = 1'b0;
        pulse_wr();
        watch(100, d, nz, na, nc);
        check(d == 47, "R5 done timing", d, 47);
        check(nz == 26, "R5 zero cycles", nz, 26);
        check(na == 7, "R5 acq cycles", na, 7);
        check(int'(result_o) == twos(13'h0123), "R5 result", int'(result_o), twos(13'h0123));
        az_n = 1'b1;
    endtask

    task automatic t_deselected();
        int d, nz, na, nc;
        cs_n = 1'b1; az_n = 1'b1;
        pulse_wr();
        watch(30, d, nz, na, nc);
        check(d == -1 && nc == 0, "R6 no start", nc, 0);
        check(ready_o == 1'b1, "R6 ready", int'(ready_o), 1);
        cs_n = 1'b0;
    endtask

    task automatic t_sample_hold();
        int d, nz, na, nc;
        target = 13'h1F00; cs_n = 1'b0;
        @(negedge clk); sh_n = 1'b0;
        @(negedge clk);
        check(acq_o && !ready_o, "R7 window open", int'({acq_o, ready_o}), 2);
        @(negedge clk);
        @(negedge clk);
        check(acq_o == 1'b1, "R7 window held", int'(acq_o), 1);
        sh_n = 1'b1;
        watch(100, d, nz, na, nc);
        check(d == 14, "R7 done timing", d, 14);
        check(int'(result_o) == twos(13'h1F00), "R7 result", int'(result_o), twos(13'h1F00));
    endtask

    task automatic t_order();
        int d, nz, na, nc;
        target = 13'h0ABC; az_n = 1'b1; cs_n = 1'b0;
        pulse_wr();
        @(negedge clk);
        check(dac_code_o == 13'h1000, "R8 sign trial", int'(dac_code_o), 'h1000);
        @(negedge clk);
        check(dac_code_o == 13'h0800, "R8 msb trial", int'(dac_code_o), 'h0800);
        @(negedge clk);
        check(dac_code_o == 13'h0C00, "R8 keep msb", int'(dac_code_o), 'h0C00);
        watch(100, d, nz, na, nc);
        check(d == 11, "R8 remaining steps", d, 11);
        check(dac_code_o == 13'h0ABC, "R8 final code", int'(dac_code_o), 'h0ABC);
        check(int'(result_o) == 'h1ABC, "R9 negative result", int'(result_o), 'h1ABC);
    endtask

    task automatic t_busy_ignore();
        int d = -1, nz = 0;
        target = 13'h0777; az_n = 1'b0; cs_n = 1'b0;
        pulse_wr();
        for (int i = 1; i <= 80; i++) begin
            @(negedge clk);
            if (zero_o) nz++;
            if (!ready_o && nz == 0 && !zero_o) nz = -100;
            if (done_o) begin d = i; break; end
            if (i == 5)  wr_n = 1'b0;
            if (i == 6)  wr_n = 1'b1;
            if (i == 30) sh_n = 1'b0;
            if (i == 31) sh_n = 1'b1;
            if (i == 40) begin wr_n = 1'b0; end
            if (i == 41) begin wr_n = 1'b1; end
        end
        check(d == 47, "R10 timing kept", d, 47);
        check(nz == 26, "R10 zero not restarted", nz, 26);
        az_n = 1'b1;
    endtask

    task automatic t_abort();
        int rdy_at = -1;
        target = 13'h0555; az_n = 1'b1; cs_n = 1'b0;
        pulse_wr();
        repeat (5) @(negedge clk);
        check(conv_o == 1'b1, "R11 conv busy", int'(conv_o), 1);
        check(ready_o == 1'b0, "R11 busy low", int'(ready_o), 0);
        cal_n = 1'b0;
        @(negedge clk);
        check(cal_ofs_o && !conv_o, "R2 abort conversion", int'({cal_ofs_o, conv_o}), 2);
        cal_n = 1'b1;
        for (int i = 1; i <= 1500; i++) begin
            @(negedge clk);
            check(!done_o, "R2 no done after abort", int'(done_o), 0);
            if (ready_o) begin rdy_at = i; break; end
        end
        check(rdy_at == 1399, "R3 cal after abort", rdy_at, 1399);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cs_n = 1'b1; wr_n = 1'b1; sh_n = 1'b1; cal_n = 1'b1; az_n = 1'b1;
        target = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_calibrate();
        t_direct(13'h0000);
        t_direct(13'h1FFF);
        t_direct(13'h1000);
        t_zeroing();
        t_deselected();
        t_sample_hold();
        t_order();
        t_busy_ignore();
        t_abort();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule